// File: doc/BRIEF.md
# Power-State Sequencer with Wake Timer, Watchdog and Calendar Counter

This block runs from the always-on low-frequency clock and decides when the core, peripheral and memory-controller clocks may run. A software command moves it from normal operation into a clock-stopped sleep. While it sleeps, it can also shut down the PLL if software asks for that when it issues the command. A down-counting timer, loaded by software, ends the sleep when it reaches zero. The block then passes through a settle phase and gives the main clocks back only once the clock-stable indication has been seen.

The same timer can be switched into a watchdog role. Software must then keep reloading it by writing a key word. If it runs out, the block raises a system reset pulse and returns to the running state. Next to the timer, a 64-bit counter advances on every low-frequency clock cycle and is never stopped. A read request captures both of its halves in the same cycle, so software always sees one coherent value. The clock-stable indication arrives from another clock domain and passes through a two-flop synchroniser before the block uses it.

Top module: `lpc_ctrl`

## Requirements
- R1: After reset, pwr_state is 0 (run), core_clk_en and pll_run are 1, wd_reset is 0, and both read outputs are 0.
- R2: The calendar counter starts at 0 and adds 1 on every clock after reset. A pulse on rtc_rd makes rtc_lo_o and rtc_hi_o show, from the next cycle on, the low and high halves of the count that was present in the cycle of the request.
- R3: A pd_req pulse while in run (state 0) moves the block to sleep (state 1) on the next edge, and core_clk_en falls with it. pd_req has no effect in states 1 and 2.
- R4: The block samples pd_stop_pll on entry to sleep. pll_run is 0 only while the state is 1 and that sample was 1.
- R5: A tmr_wr pulse loads tmr_wr_val into the timer and arms it. An armed timer counts down once per cycle and, on the cycle it holds 0, expires and disarms. A tmr_wr in that same cycle wins over the expiry.
- R6: When the timer expires in alarm mode (tmr_wd_sel=0) and the block is asleep, the block enters settle (state 2). Settle first counts down settle_len cycles if the PLL was stopped, or no cycles otherwise. After that it returns to run on the first cycle in which the synchronised stable flag is 1.
- R7: clk_stable_in reaches the settle logic only after two register stages.
- R8: In watchdog mode, a kick_wr carrying KEY (default 16'hC35A) reloads the timer with the last value written by tmr_wr. A kick with any other value, or any kick in alarm mode, leaves the count unchanged.
- R9: A watchdog-mode expiry forces the state to run and drives wd_reset high for RST_LEN (default 2, at least 2) consecutive cycles, starting on the next cycle.
- R10: An expiry in alarm mode while running does not change the state and does not raise wd_reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-frequency clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_req | input | 1 | Request to enter sleep |
| pd_stop_pll | input | 1 | Stop the PLL during this sleep |
| settle_len | input | SETTLE_W | Settle cycles after a stopped PLL |
| clk_stable_in | input | 1 | Asynchronous main-clock-stable flag |
| tmr_wr | input | 1 | Load and arm the timer |
| tmr_wr_val | input | TMR_W | Timer load value |
| tmr_wd_sel | input | 1 | 1 selects watchdog mode, 0 selects alarm mode |
| kick_wr | input | 1 | Watchdog service write strobe |
| kick_val | input | KEY_W | Watchdog service data |
| rtc_rd | input | 1 | Capture the calendar counter |
| rtc_lo_o | output | RTC_W/2 | Captured low half |
| rtc_hi_o | output | RTC_W/2 | Captured high half |
| core_clk_en | output | 1 | Enable for the core, peripheral and memory clocks |
| pll_run | output | 1 | PLL enable |
| wd_reset | output | 1 | Watchdog system reset pulse |
| pwr_state | output | 2 | 0 run, 1 sleep, 2 settle |

## Verification
The hardest case to reach from the ports is a settle phase that has to wait on the synchroniser after its own count has run out. The bench stops the PLL, lowers clk_stable_in before the wake timer expires and raises it only several cycles into settle, so the two-cycle delay shows up in the exit cycle. A second hard case is a watchdog expiry while the block is asleep. The bench services the watchdog with both the key and a wrong word, then lets it lapse during sleep, and checks the forced return to run and the reset pulse on every cycle.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
    typedef enum logic [1:0] {
        PS_RUN    = 2'd0,
        PS_DOWN   = 2'd1,
        PS_SETTLE = 2'd2
    } pwr_state_e;
endpackage

// File: rtl/lpc_sync.sv
// Two-flop synchroniser for single-bit flags entering the low-power domain.
module lpc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.s1 = d_in;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign d_out = q.s2;
endmodule

// File: rtl/lpc_rtc.sv
// Free-running calendar counter with a coherent two-half capture.
module lpc_rtc #(
    parameter int RTC_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_req,
    output logic [RTC_W/2-1:0] lo_o,
    output logic [RTC_W/2-1:0] hi_o,
    output logic [RTC_W-1:0]   cnt_o
);
    localparam int HALF = RTC_W / 2;

    typedef struct packed {
        logic [RTC_W-1:0] cnt;
        logic [HALF-1:0]  lo;
        logic [HALF-1:0]  hi;
    } rtc_t;

    rtc_t q, d;

    always_comb begin
        d     = q;
        d.cnt = q.cnt + 1'b1;
        if (rd_req) begin
            d.lo = q.cnt[HALF-1:0];
            d.hi = q.cnt[RTC_W-1:HALF];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lo_o  = q.lo;
    assign hi_o  = q.hi;
    assign cnt_o = q.cnt;
endmodule

// File: rtl/lpc_timer.sv
// Shared down-counter: wake alarm or keyed watchdog with a reset pulse stretcher.
module lpc_timer #(
    parameter int              TMR_W   = 16,
    parameter int              KEY_W   = 16,
    parameter logic [KEY_W-1:0] KEY    = 16'hC35A,
    parameter int              RST_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             wd_sel,
    input  logic             kick,
    input  logic [KEY_W-1:0] kick_val,
    output logic             alarm_fire,
    output logic             wd_fire,
    output logic             wd_rst
);
    localparam int RC_W = $clog2(RST_LEN + 1);

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
        logic [TMR_W-1:0] reload;
        logic             armed;
        logic [RC_W-1:0]  rst_cnt;
    } tmr_t;

    tmr_t q, d;
    logic expire;

    always_comb begin
        expire = q.armed && (q.cnt == '0) && !load;
        d      = q;
        if (q.rst_cnt != '0) d.rst_cnt = q.rst_cnt - 1'b1;
        if (load) begin
            d.cnt    = load_val;
            d.reload = load_val;
            d.armed  = 1'b1;
        end else if (q.armed) begin
            if (q.cnt == '0)                              d.armed = 1'b0;
            else if (wd_sel && kick && (kick_val == KEY)) d.cnt   = q.reload;
            else                                          d.cnt   = q.cnt - 1'b1;
        end
        if (expire && wd_sel) d.rst_cnt = RC_W'(RST_LEN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign alarm_fire = expire && !wd_sel;
    assign wd_fire    = expire && wd_sel;
    assign wd_rst     = (q.rst_cnt != '0);
endmodule

// File: rtl/lpc_ctrl.sv
// Power-state sequencer: run / sleep / settle, driven from the low-power clock.
module lpc_ctrl
    import lpc_pkg::*;
#(
    parameter int               RTC_W    = 64,
    parameter int               TMR_W    = 16,
    parameter int               SETTLE_W = 8,
    parameter int               KEY_W    = 16,
    parameter logic [KEY_W-1:0] KEY      = 16'hC35A,
    parameter int               RST_LEN  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pd_req,
    input  logic                pd_stop_pll,
    input  logic [SETTLE_W-1:0] settle_len,
    input  logic                clk_stable_in,
    input  logic                tmr_wr,
    input  logic [TMR_W-1:0]    tmr_wr_val,
    input  logic                tmr_wd_sel,
    input  logic                kick_wr,
    input  logic [KEY_W-1:0]    kick_val,
    input  logic                rtc_rd,
    output logic [RTC_W/2-1:0]  rtc_lo_o,
    output logic [RTC_W/2-1:0]  rtc_hi_o,
    output logic                core_clk_en,
    output logic                pll_run,
    output logic                wd_reset,
    output logic [1:0]          pwr_state
);
    typedef struct packed {
        pwr_state_e          st;
        logic                pll_off;
        logic [SETTLE_W-1:0] settle;
    } fsm_t;

    fsm_t q, d;
    logic stable_s;
    logic alarm_fire;
    logic wd_fire;
    logic [RTC_W-1:0] rtc_cnt;

    lpc_sync #(.W(1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (clk_stable_in),
        .d_out (stable_s)
    );

    lpc_rtc #(.RTC_W(RTC_W)) u_rtc (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_req (rtc_rd),
        .lo_o   (rtc_lo_o),
        .hi_o   (rtc_hi_o),
        .cnt_o  (rtc_cnt)
    );

    lpc_timer #(
        .TMR_W   (TMR_W),
        .KEY_W   (KEY_W),
        .KEY     (KEY),
        .RST_LEN (RST_LEN)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (tmr_wr),
        .load_val   (tmr_wr_val),
        .wd_sel     (tmr_wd_sel),
        .kick       (kick_wr),
        .kick_val   (kick_val),
        .alarm_fire (alarm_fire),
        .wd_fire    (wd_fire),
        .wd_rst     (wd_reset)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            PS_RUN: begin
                if (pd_req) begin
                    d.st      = PS_DOWN;
                    d.pll_off = pd_stop_pll;
                end
            end
            PS_DOWN: begin
                if (alarm_fire) begin
                    d.st     = PS_SETTLE;
                    d.settle = q.pll_off ? settle_len : '0;
                end
            end
            PS_SETTLE: begin
                if (q.settle != '0) d.settle = q.settle - 1'b1;
                else if (stable_s)  d.st     = PS_RUN;
            end
            default: d.st = PS_RUN;
        endcase
        if (wd_fire) d.st = PS_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: PS_RUN, pll_off: 1'b0, settle: '0};
        else        q <= d;
    end

    assign core_clk_en = (q.st == PS_RUN);
    assign pll_run     = !((q.st == PS_DOWN) && q.pll_off);
    assign pwr_state   = q.st;
endmodule

// File: rtl/lpc_ctrl_chk.sv
module lpc_ctrl_chk #(
    parameter int RTC_W = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pd_req,
    input logic [1:0]         pwr_state,
    input logic               core_clk_en,
    input logic               pll_run,
    input logic               wd_reset,
    input logic               rtc_rd,
    input logic [RTC_W/2-1:0] rtc_lo_o,
    input logic [RTC_W/2-1:0] rtc_hi_o,
    input logic [RTC_W-1:0]   rtc_cnt
);
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> rtc_cnt == $past(rtc_cnt) + 1'b1);

    a_r2_coherent_read: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_rd |=> {rtc_hi_o, rtc_lo_o} == $past(rtc_cnt));

    a_r3_enter_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && pd_req) |=> (pwr_state == 2'd1 || $rose(wd_reset)));

    a_r3_gated_off_run: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'd0) |-> !core_clk_en);

    a_r4_pll_on_awake: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'd1) |-> pll_run);

    a_r6_settle_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd2) |=> (pwr_state == 2'd2 || pwr_state == 2'd0));

    a_r9_min_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_reset) |=> wd_reset);

    a_r9_forced_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_reset) |-> pwr_state == 2'd0);
endmodule

bind lpc_ctrl lpc_ctrl_chk #(.RTC_W(RTC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pd_req      (pd_req),
    .pwr_state   (pwr_state),
    .core_clk_en (core_clk_en),
    .pll_run     (pll_run),
    .wd_reset    (wd_reset),
    .rtc_rd      (rtc_rd),
    .rtc_lo_o    (rtc_lo_o),
    .rtc_hi_o    (rtc_hi_o),
    .rtc_cnt     (rtc_cnt)
);

// File: tb/sim_lpc_ctrl.sv
`timescale 1ns/1ps
module sim_lpc_ctrl;
    localparam logic [15:0] KEY = 16'hC35A;
    localparam int RST_LEN = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_req = 0, pd_stop_pll = 0, clk_stable_in = 0;
    logic [7:0] settle_len = 8'd0;
    logic tmr_wr = 0, tmr_wd_sel = 0, kick_wr = 0, rtc_rd = 0;
    logic [15:0] tmr_wr_val = '0, kick_val = '0;
    logic [31:0] rtc_lo_o, rtc_hi_o;
    logic core_clk_en, pll_run, wd_reset;
    logic [1:0] pwr_state;

    always #2.5 clk = ~clk;

    lpc_ctrl u0 (.*);

    int tests = 0, fails = 0;
    bit done = 0;
    string req = "R1";

    // reference model
    logic [63:0] m_rtc = '0;
    logic [31:0] m_lo = '0, m_hi = '0;
    int m_tmr = 0, m_reload = 0, m_rstc = 0, m_state = 0, m_settle = 0;
    bit m_armed = 0, m_plloff = 0, m_s1 = 0, m_s2 = 0;

    task automatic model_step();
        bit expire;
        bit stbl;
        expire = m_armed && m_tmr == 0 && !tmr_wr;
        stbl = m_s2;
        m_s2 = m_s1; m_s1 = clk_stable_in;
        if (rtc_rd) begin m_lo = m_rtc[31:0]; m_hi = m_rtc[63:32]; end
        m_rtc = m_rtc + 64'd1;
        if (m_rstc > 0) m_rstc--;
        if (tmr_wr) begin m_tmr = tmr_wr_val; m_reload = tmr_wr_val; m_armed = 1; end
        else if (m_armed) begin
            if (m_tmr == 0) m_armed = 0;
            else if (tmr_wd_sel && kick_wr && kick_val == KEY) m_tmr = m_reload;
            else m_tmr--;
        end
        if (expire && tmr_wd_sel) m_rstc = RST_LEN;
        case (m_state)
            0: if (pd_req) begin m_state = 1; m_plloff = pd_stop_pll; end
            1: if (expire && !tmr_wd_sel) begin m_state = 2; m_settle = m_plloff ? settle_len : 0; end
            2: if (m_settle > 0) m_settle--; else if (stbl) m_state = 0;
            default: ;
        endcase
        if (expire && tmr_wd_sel) m_state = 0;
    endtask

    task automatic chk(string what, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("pwr_state", pwr_state, m_state);
        chk("core_clk_en", core_clk_en, m_state == 0);
        chk("pll_run", pll_run, !(m_state == 1 && m_plloff));
        chk("wd_reset", wd_reset, m_rstc != 0);
        chk("rtc_lo_o", rtc_lo_o, m_lo);
        chk("rtc_hi_o", rtc_hi_o, m_hi);
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            if (rst_n) model_step();
            @(negedge clk);
            compare();
            pd_req = 0; tmr_wr = 0; kick_wr = 0; rtc_rd = 0;
        end
    endtask

    task automatic wait_state(int s, int lim);
        for (int i = 0; i < lim && m_state != s; i++) tick();
    endtask

    initial begin
        #(5ns * 20000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset values
        req = "R1";
        tick(3);
        @(negedge clk); rst_n = 1;
        compare();
        // R2: counter and coherent read
        req = "R2";
        tick(5); rtc_rd = 1; tick(); tick(3); rtc_rd = 1; tick(2);
        // R7: synchroniser
        req = "R7";
        clk_stable_in = 1; tick(4);
        // R10: alarm expiry while running
        req = "R10";
        tmr_wr = 1; tmr_wr_val = 16'd3; tick(); tick(6);
        // R3/R5/R6: sleep without PLL stop, alarm wake
        req = "R3";
        pd_req = 1; pd_stop_pll = 0; tick(); pd_req = 1; tick();
        req = "R5";
        tmr_wr = 1; tmr_wr_val = 16'd4; tick(); tick(2);
        tmr_wr = 1; tmr_wr_val = 16'd2; tick();
        req = "R6";
        wait_state(0, 30); tick(2);
        // R4/R6/R7: PLL stopped, late stable
        req = "R4";
        settle_len = 8'd3; pd_stop_pll = 1; pd_req = 1; tick();
        clk_stable_in = 0;
        tmr_wr = 1; tmr_wr_val = 16'd5; tick(); tick(3);
        req = "R6";
        wait_state(2, 30); tick(6);
        req = "R7";
        clk_stable_in = 1; tick(5);
        // R8: watchdog kicks
        req = "R8";
        tmr_wd_sel = 1; pd_stop_pll = 0;
        tmr_wr = 1; tmr_wr_val = 16'd6; tick(); tick(3);
        kick_wr = 1; kick_val = KEY; tick(); tick(3);
        kick_wr = 1; kick_val = 16'h1234; tick(); tick(1);
        kick_wr = 1; kick_val = KEY; tick(); tick(2);
        // R9: lapse during sleep
        req = "R9";
        pd_req = 1; pd_stop_pll = 1; tick();
        wait_state(0, 30); tick(6);
        // R8: kick in alarm mode has no effect
        req = "R8";
        tmr_wd_sel = 0; tmr_wr = 1; tmr_wr_val = 16'd4; tick();
        pd_req = 1; pd_stop_pll = 0; tick();
        kick_wr = 1; kick_val = KEY; tick();
        wait_state(0, 30); tick(2);
        rtc_rd = 1; tick(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule